// File: doc/BRIEF.md
# Prioritized CPU Exception Dispatcher

This block decides which pending CPU exception to take and computes the processor state that results from taking it. The surrounding core presents a vector of pending-exception flags and its current machine state word, program counter, next program counter and the two save/restore registers. It then pulses a check strobe. One cycle later the block presents the updated state. At most one exception is serviced per check. Any other pending flags are left set for later checks.

Exceptions fall into two tiers. The synchronous tier always wins and is taken in a fixed order. The external tier is considered only when no synchronous flag is pending, and only while the external-enable bit of the machine state word is set. When an exception is vectored, the block saves a return address and a masked copy of the machine state. It then moves the interrupt-endian bit into the endian bit, clears a fixed set of state bits, and points both program counters at the exception's entry vector. A debug memory-check hit is handled differently: it cancels a pending data fault and takes no vector. An external-class flag of unknown type, seen while external events are enabled, raises an error pulse instead.

Top module: `exc_dispatch`

## Requirements
- R1: Pending bit map: 0 instruction-fetch fault, 1 program, 2 system call, 3 FPU unavailable, 4 debug hit, 5 data fault, 6 alignment, 7 external interrupt, 8 performance monitor, 9 decrementer, 10 and up unknown external-class. The lowest set bit among 0..6 is serviced first, and `exc_idx_o` reports the serviced bit together with `taken_o`.
- R2: Bits 7..9 are considered only when bits 0..6 are all clear and machine state bit 15 (external enable) is 1. Among them the lowest set bit wins. When bit 15 is 0 they stay pending and nothing is taken.
- R3: On a vectored exception, `srr1_o` = machine state AND 0x87C0FFFF. For an instruction-fetch fault, bit 30 is also set.
- R4: For a program exception, `srr1_o` = `srr1_i` OR (machine state AND 0x87C0FFFF), which keeps the pre-loaded cause bits.
- R5: On a vectored exception, the new machine state copies bit 16 into bit 0, then clears every bit of 0x0004EF36.
- R6: Entry vectors: data fault 0x300, fetch fault 0x400, external 0x500, alignment 0x600, program 0x700, FPU 0x800, decrementer 0x900, system call 0xC00, performance monitor 0xF00. `pc_o` and `npc_o` both take the vector.
- R7: `srr0_o` takes `npc_i` for fetch fault, system call, external, performance monitor and decrementer. It takes `pc_i` for program, FPU, data fault and alignment.
- R8: A debug hit (bit 4 as winner) clears bits 4 and 5. `taken_o` stays 0, and the machine state, program counters and save/restore outputs equal their inputs.
- R9: The outputs update only on a cycle with `check_i` high and appear one clock later. `taken_o` is a one-cycle pulse. The serviced bit is the only bit cleared in `pend_o`.
- R10: With bits 0..9 clear, bit 15 set and any bit at 10 or above set, `err_o` pulses and all state outputs equal the inputs, with `pend_o` unchanged.
- R11: After a synchronous active-high reset, every output is 0.
- R12: A check with nothing serviceable pending copies all inputs to the outputs, with `taken_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_i | input | 1 | Dispatch strobe |
| pend_i | input | PEND_W | Pending exception flags |
| msr_i | input | 32 | Current machine state word |
| pc_i | input | 32 | Current program counter |
| npc_i | input | 32 | Next program counter |
| srr0_i | input | 32 | Current save/restore register 0 |
| srr1_i | input | 32 | Current save/restore register 1 (pre-loaded cause bits) |
| taken_o | output | 1 | One-cycle pulse: an exception was vectored |
| err_o | output | 1 | One-cycle pulse: unknown external-class event |
| exc_idx_o | output | IDX_W | Bit index of the vectored exception |
| pend_o | output | PEND_W | Updated pending flags |
| msr_o | output | 32 | Updated machine state word |
| pc_o | output | 32 | Updated program counter |
| npc_o | output | 32 | Updated next program counter |
| srr0_o | output | 32 | Updated save/restore register 0 |
| srr1_o | output | 32 | Updated save/restore register 1 |

## Verification
The bench builds the block with two unknown external-class bits, giving a 12-bit pending vector and a 4-bit index. This makes the error path reachable, and the bench can check that unknown types never win over known ones. Random pending vectors with a low density per bit mix both tiers and the enable bit. Directed cases cover the data-fault cancel by a debug hit, the preserved program cause bits, and the gated external tier.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XW = 32;

  localparam int unsigned B_IFETCH = 0;
  localparam int unsigned B_PROG   = 1;
  localparam int unsigned B_SYSC   = 2;
  localparam int unsigned B_FPU    = 3;
  localparam int unsigned B_DBG    = 4;
  localparam int unsigned B_DFLT   = 5;
  localparam int unsigned B_ALGN   = 6;
  localparam int unsigned B_EXT    = 7;
  localparam int unsigned B_PERF   = 8;
  localparam int unsigned B_DEC    = 9;
  localparam int unsigned N_SYNC   = 7;
  localparam int unsigned N_KNOWN  = 10;

  localparam int unsigned EE_BIT  = 15;
  localparam int unsigned LE_BIT  = 0;
  localparam int unsigned ILE_BIT = 16;

  localparam logic [XW-1:0] SAVE_MASK   = 32'h87C0_FFFF;
  localparam logic [XW-1:0] CLR_MASK    = 32'h0004_EF36;
  localparam logic [XW-1:0] IFETCH_FLAG = 32'h4000_0000;

  function automatic logic [XW-1:0] entry_vec(input int unsigned b);
    logic [XW-1:0] v;
    case (b)
      B_IFETCH: v = 32'h0000_0400;
      B_PROG:   v = 32'h0000_0700;
      B_SYSC:   v = 32'h0000_0C00;
      B_FPU:    v = 32'h0000_0800;
      B_DFLT:   v = 32'h0000_0300;
      B_ALGN:   v = 32'h0000_0600;
      B_EXT:    v = 32'h0000_0500;
      B_PERF:   v = 32'h0000_0F00;
      B_DEC:    v = 32'h0000_0900;
      default:  v = '0;
    endcase
    return v;
  endfunction

  // 1: the faulting instruction is re-executed, so the current PC is saved
  function automatic logic saves_pc(input int unsigned b);
    return (b == B_PROG) || (b == B_FPU) || (b == B_DFLT) || (b == B_ALGN);
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
#(
  parameter int unsigned PEND_W = 12,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [PEND_W-1:0] pend_i,
  input  logic              ee_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              err_o
);
  logic [PEND_W-1:0] elig;
  logic              sync_any;
  logic              ext_any;

  assign sync_any = |pend_i[N_SYNC-1:0];
  assign ext_any  = |pend_i[N_KNOWN-1:N_SYNC];

  // synchronous tier shadows the external tier completely
  always_comb begin
    elig = '0;
    if (sync_any)
      elig[N_SYNC-1:0] = pend_i[N_SYNC-1:0];
    else if (ee_i)
      elig[N_KNOWN-1:N_SYNC] = pend_i[N_KNOWN-1:N_SYNC];
  end

  // lowest eligible index has the highest priority
  always_comb begin
    idx_o = '0;
    for (int i = PEND_W - 1; i >= 0; i--)
      if (elig[i]) idx_o = IDX_W'(i);
  end

  assign hit_o = |elig;

  generate
    if (PEND_W > N_KNOWN) begin : g_unknown
      assign err_o = !sync_any && ee_i && !ext_any && (|pend_i[PEND_W-1:N_KNOWN]);
    end else begin : g_no_unknown
      assign err_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
  import exc_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XW-1:0]    msr_i,
  input  logic [XW-1:0]    pc_i,
  input  logic [XW-1:0]    npc_i,
  input  logic [XW-1:0]    srr1_i,
  output logic             vectored_o,
  output logic [XW-1:0]    msr_o,
  output logic [XW-1:0]    vec_o,
  output logic [XW-1:0]    srr0_o,
  output logic [XW-1:0]    srr1_o
);
  int unsigned   b;
  logic [XW-1:0] saved;
  logic [XW-1:0] msr_le;

  assign b          = int'(idx_i);
  assign vectored_o = (b != B_DBG);
  assign saved      = msr_i & SAVE_MASK;
  assign vec_o      = entry_vec(b);
  assign srr0_o     = saves_pc(b) ? pc_i : npc_i;

  always_comb begin
    msr_le         = msr_i;
    msr_le[LE_BIT] = msr_i[ILE_BIT];
    msr_o          = msr_le & ~CLR_MASK;
  end

  always_comb begin
    case (b)
      B_IFETCH: srr1_o = saved | IFETCH_FLAG;
      B_PROG:   srr1_o = srr1_i | saved;
      default:  srr1_o = saved;
    endcase
  end
endmodule

// File: rtl/exc_pend_upd.sv
module exc_pend_upd
  import exc_pkg::*;
#(
  parameter int unsigned PEND_W = 12,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [PEND_W-1:0] pend_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PEND_W-1:0] pend_o
);
  logic dbg_win;
  assign dbg_win = hit_i && (int'(idx_i) == B_DBG);

  generate
    for (genvar g = 0; g < PEND_W; g++) begin : g_bit
      logic clr;
      if (g == B_DFLT) begin : g_dflt
        assign clr = hit_i && ((int'(idx_i) == g) || dbg_win);
      end else begin : g_plain
        assign clr = hit_i && (int'(idx_i) == g);
      end
      assign pend_o[g] = pend_i[g] && !clr;
    end
  endgenerate
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int unsigned EXT_EXTRA = 2,
  localparam int unsigned PEND_W   = N_KNOWN + EXT_EXTRA,
  localparam int unsigned IDX_W    = $clog2(PEND_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              check_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [XW-1:0]     msr_i,
  input  logic [XW-1:0]     pc_i,
  input  logic [XW-1:0]     npc_i,
  input  logic [XW-1:0]     srr0_i,
  input  logic [XW-1:0]     srr1_i,
  output logic              taken_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  exc_idx_o,
  output logic [PEND_W-1:0] pend_o,
  output logic [XW-1:0]     msr_o,
  output logic [XW-1:0]     pc_o,
  output logic [XW-1:0]     npc_o,
  output logic [XW-1:0]     srr0_o,
  output logic [XW-1:0]     srr1_o
);
  logic              hit, ext_err, vect;
  logic [IDX_W-1:0]  sel;
  logic [XW-1:0]     msr_n, vec_n, srr0_n, srr1_n;
  logic [PEND_W-1:0] pend_n;

  exc_prio_sel #(.PEND_W(PEND_W), .IDX_W(IDX_W)) u_sel (
    .pend_i(pend_i), .ee_i(msr_i[EE_BIT]),
    .hit_o(hit), .idx_o(sel), .err_o(ext_err)
  );

  exc_ctx_calc #(.IDX_W(IDX_W)) u_ctx (
    .idx_i(sel), .msr_i(msr_i), .pc_i(pc_i), .npc_i(npc_i), .srr1_i(srr1_i),
    .vectored_o(vect), .msr_o(msr_n), .vec_o(vec_n),
    .srr0_o(srr0_n), .srr1_o(srr1_n)
  );

  exc_pend_upd #(.PEND_W(PEND_W), .IDX_W(IDX_W)) u_pend (
    .pend_i(pend_i), .hit_i(hit), .idx_i(sel), .pend_o(pend_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      err_o     <= 1'b0;
      exc_idx_o <= '0;
      pend_o    <= '0;
      msr_o     <= '0;
      pc_o      <= '0;
      npc_o     <= '0;
      srr0_o    <= '0;
      srr1_o    <= '0;
    end else begin
      taken_o <= 1'b0;
      err_o   <= 1'b0;
      if (check_i) begin
        pend_o <= pend_n;
        err_o  <= ext_err;
        if (hit && vect) begin
          taken_o   <= 1'b1;
          exc_idx_o <= sel;
          msr_o     <= msr_n;
          pc_o      <= vec_n;
          npc_o     <= vec_n;
          srr0_o    <= srr0_n;
          srr1_o    <= srr1_n;
        end else begin
          msr_o  <= msr_i;
          pc_o   <= pc_i;
          npc_o  <= npc_i;
          srr0_o <= srr0_i;
          srr1_o <= srr1_i;
        end
      end
    end
  end

  // R9: pulses appear only in the cycle after a check
  assert_pulse_after_check_R9: assert property (@(posedge clk) disable iff (rst)
    (taken_o || err_o) |-> $past(check_i));

  // R9: exactly one pending bit removed by a vectored exception
  assert_one_bit_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ($countones($past(pend_i) ^ pend_o) == 1));

  // R6: both counters land on the same nonzero, 256-byte aligned vector
  assert_vector_shape_R6: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (pc_o == npc_o) && (pc_o[7:0] == 8'h00) && (pc_o != '0));

  // R5: cleared state bits are zero after vectoring
  assert_msr_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ((msr_o & CLR_MASK) == '0));

  // R2: external-tier service requires the enable bit
  assert_ext_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (taken_o && (int'(exc_idx_o) >= N_SYNC)) |-> $past(msr_i[EE_BIT]));

  // R10: error leaves the state untouched and never coincides with a take
  assert_err_holds_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !taken_o && (pc_o == $past(pc_i)) && (msr_o == $past(msr_i))
              && (pend_o == $past(pend_i)));
endmodule

// File: tb/sim_exc_dispatch.sv
module sim_exc_dispatch;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          check_i = 1'b0;
  logic [PW-1:0] pend_i = '0;
  logic [31:0]   msr_i = '0, pc_i = '0, npc_i = '0, srr0_i = '0, srr1_i = '0;
  logic          taken_o, err_o;
  logic [3:0]    exc_idx_o;
  logic [PW-1:0] pend_o;
  logic [31:0]   msr_o, pc_o, npc_o, srr0_o, srr1_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exc_dispatch #(.EXT_EXTRA(2)) u0 (
    .clk(clk), .rst(rst), .check_i(check_i), .pend_i(pend_i), .msr_i(msr_i),
    .pc_i(pc_i), .npc_i(npc_i), .srr0_i(srr0_i), .srr1_i(srr1_i),
    .taken_o(taken_o), .err_o(err_o), .exc_idx_o(exc_idx_o), .pend_o(pend_o),
    .msr_o(msr_o), .pc_o(pc_o), .npc_o(npc_o), .srr0_o(srr0_o), .srr1_o(srr1_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected state after one check, derived from the requirement text
  logic          e_taken, e_err;
  logic [3:0]    e_idx;
  logic [PW-1:0] e_pend;
  logic [31:0]   e_msr, e_pc, e_npc, e_s0, e_s1;

  task automatic model(input logic [PW-1:0] p, input logic [31:0] m, pc, npc, s0, s1);
    int k;
    k = -1;
    e_taken = 0; e_err = 0; e_idx = 0; e_pend = p;
    e_msr = m; e_pc = pc; e_npc = npc; e_s0 = s0; e_s1 = s1;
    for (int i = 6; i >= 0; i--) if (p[i]) k = i;
    if (k < 0 && m[15]) begin
      for (int i = 9; i >= 7; i--) if (p[i]) k = i;
      if (k < 0 && p[11:10] != 0) e_err = 1;
    end
    if (k == 4) begin
      e_pend[4] = 0; e_pend[5] = 0;
    end else if (k >= 0) begin
      e_taken = 1; e_idx = 4'(k); e_pend[k] = 0;
      case (k)
        0: begin e_pc = 32'h400; e_s0 = npc; end
        1: begin e_pc = 32'h700; e_s0 = pc;  end
        2: begin e_pc = 32'hC00; e_s0 = npc; end
        3: begin e_pc = 32'h800; e_s0 = pc;  end
        5: begin e_pc = 32'h300; e_s0 = pc;  end
        6: begin e_pc = 32'h600; e_s0 = pc;  end
        7: begin e_pc = 32'h500; e_s0 = npc; end
        8: begin e_pc = 32'hF00; e_s0 = npc; end
        default: begin e_pc = 32'h900; e_s0 = npc; end
      endcase
      e_npc = e_pc;
      e_s1 = m & 32'h87C0FFFF;
      if (k == 0) e_s1 = e_s1 | 32'h40000000;
      if (k == 1) e_s1 = e_s1 | s1;
      e_msr = {m[31:1], m[16]} & ~32'h0004EF36;
    end
  endtask

  task automatic run(input string tag, input logic [PW-1:0] p,
                     input logic [31:0] m, pc, npc, s0, s1);
    @(negedge clk);
    pend_i = p; msr_i = m; pc_i = pc; npc_i = npc; srr0_i = s0; srr1_i = s1;
    check_i = 1'b1;
    model(p, m, pc, npc, s0, s1);
    @(posedge clk);
    @(negedge clk);
    check_i = 1'b0;
    chk({tag, " R1 taken"}, 32'(taken_o), 32'(e_taken));
    if (e_taken) chk({tag, " R1 idx"}, 32'(exc_idx_o), 32'(e_idx));
    chk({tag, " R10 err"}, 32'(err_o), 32'(e_err));
    chk({tag, " R9 pend"}, 32'(pend_o), 32'(e_pend));
    chk({tag, " R5 msr"}, msr_o, e_msr);
    chk({tag, " R6 pc"}, pc_o, e_pc);
    chk({tag, " R6 npc"}, npc_o, e_npc);
    chk({tag, " R7 srr0"}, srr0_o, e_s0);
    chk({tag, " R3 srr1"}, srr1_o, e_s1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: all outputs zero while in reset
    chk("R11 reset taken", 32'(taken_o), 0);
    chk("R11 reset err", 32'(err_o), 0);
    chk("R11 reset pend", 32'(pend_o), 0);
    chk("R11 reset msr", msr_o, 0);
    chk("R11 reset pc", pc_o, 0);
    chk("R11 reset srr1", srr1_o, 0);
    rst = 1'b0;

    // directed corners
    run("R1 fetch-fault", 12'h001, 32'h0001_8035, 32'h100, 32'h104, 32'h1, 32'h2);
    run("R4 program keeps cause", 12'h002, 32'hFFFF_FFFF, 32'h200, 32'h204, 32'h0, 32'h0002_0000);
    run("R7 syscall npc", 12'h004, 32'h0000_8000, 32'h300, 32'h304, 32'h0, 32'h0);
    run("R7 fpu pc", 12'h008, 32'h0001_0000, 32'h400, 32'h404, 32'h0, 32'h0);
    run("R8 debug cancels data fault", 12'h030, 32'h0001_8000, 32'h500, 32'h504, 32'h55, 32'h66);
    run("R8 debug alone", 12'h010, 32'h0, 32'h600, 32'h604, 32'h77, 32'h88);
    run("R6 data fault", 12'h020, 32'h0, 32'h700, 32'h704, 32'h0, 32'h0);
    run("R6 alignment", 12'h040, 32'h0, 32'h800, 32'h804, 32'h0, 32'h0);
    run("R2 sync beats ext", 12'h3C0, 32'h0000_8000, 32'h10, 32'h14, 32'h0, 32'h0);
    run("R2 ext int first", 12'h380, 32'h0000_8000, 32'h20, 32'h24, 32'h0, 32'h0);
    run("R2 perf before dec", 12'h300, 32'h0000_8000, 32'h30, 32'h34, 32'h0, 32'h0);
    run("R2 dec", 12'h200, 32'h0001_8000, 32'h40, 32'h44, 32'h0, 32'h0);
    run("R2 gated by enable", 12'h380, 32'h0000_7FFF, 32'h50, 32'h54, 32'h9, 32'hA);
    run("R10 unknown ext", 12'hC00, 32'h0000_8000, 32'h60, 32'h64, 32'hB, 32'hC);
    run("R10 known beats unknown", 12'hD00, 32'h0000_8000, 32'h70, 32'h74, 32'h0, 32'h0);
    run("R12 nothing pending", 12'h000, 32'h1234_5678, 32'h80, 32'h84, 32'hD, 32'hE);

    // R9: one-cycle pulse, outputs hold with no check
    run("R9 before hold", 12'h004, 32'h0, 32'h90, 32'h94, 32'h0, 32'h0);
    @(negedge clk);
    pc_i = 32'hDEAD_BEEF; pend_i = '1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 pulse ends", 32'(taken_o), 0);
    chk("R9 pc held", pc_o, 32'hC00);
    chk("R9 pend held", 32'(pend_o), 32'h0);

    // constrained random mix of both tiers
    for (int it = 0; it < 400; it++) begin
      logic [PW-1:0] p;
      logic [31:0] m;
      p = PW'($urandom & $urandom & $urandom);
      if (it % 3 == 0) p[6:0] = '0;
      m = $urandom;
      r = $urandom;
      run("R1 random", p, m, $urandom, $urandom, $urandom, r);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule